// File: doc/BRIEF.md
# Dual-Mode Video Sync Processor

This block recovers line, field and active-picture timing from an 8-bit 4:2:2 sample stream clocked at 27 MHz. The clock is taken to be synchronous to the samples. The timing comes from one of two sources, chosen by a configuration pin. In embedded mode, four-byte timing reference codes inside the stream mark the start and the end of each line's picture. In external mode, three separate pins carry horizontal blanking, vertical blanking and field identity. Both sources are reduced to the same internal events. A single timing core then turns those events into the outputs that a downstream formatter needs.

The formatter receives a qualified picture-sample stream and a line number within the frame. It also receives an odd-field flag and one-cycle pulses at the start of each line and at each field change. The sample stream runs with valid only, and it cannot be back-pressured. The source marks each real sample with `in_valid` and cannot be stalled. The consumer must take every cycle in which `act_valid` is high. The line standard (525 or 625 lines per frame) and the field-identity polarity are static configuration pins. They are changed only while the block is held in reset.

Top module: `video_sync_proc`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, `act_valid`, `sol_pulse`, `sof_pulse`, `field_odd`, `sync_err` and `line_cnt` are all zero.
- R2: In embedded mode, a timing code is four consecutive valid samples FFh, 00h, 00h, XY. In XY, bit 4 set marks an end-of-active event and bit 4 clear marks a start-of-active event. Bit 5 is the vertical-blank flag and bit 6 is the raw field bit. Bits 3..0 have no effect on any output.
- R3: After a start-of-active event, exactly ACT_SAMPLES valid samples are passed out with `act_valid` high and the sample on `act_data`, one clock after they are taken in. In embedded mode these are the samples after XY. In external mode the window starts with the sample on which `ext_hblank` falls. No sample is marked while the line's vertical-blank flag is set.
- R4: `sol_pulse` is high for exactly one cycle, one clock after each start-of-active event.
- R5: At each end-of-active event, `field_odd` takes the value (raw field bit == `cfg_fid_inv`), in both modes. `sof_pulse` is high for one cycle exactly when this value differs from the previous one.
- R6: At each end-of-active event, `line_cnt` becomes 0 if the field just changed to odd. Otherwise it adds one, wrapping to 0 after LINES_625-1 when `cfg_std625`=1 and after LINES_525-1 when `cfg_std625`=0.
- R7: In external mode, a rising `ext_hblank` between consecutive valid samples is an end-of-active event and a falling one is a start-of-active event. `ext_vblank` and `ext_fid` are sampled on the end-of-active sample.
- R8: In embedded mode, `sync_err` rises when more than LINE_CLKS+MARGIN clocks pass without an end-of-active event. It clears with the next such event. A byte run that is not a full timing code does not clear it.
- R9: A cycle with `in_valid` low is ignored. It produces no `act_valid`, and a timing code split by such cycles is still recognised.
- R10: In external mode, `sync_err` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 27 MHz |
| rst_n | input | 1 | Active-low reset |
| cfg_ext_mode | input | 1 | 1 = external sync pins, 0 = embedded codes |
| cfg_std625 | input | 1 | 1 = 625-line frame, 0 = 525-line frame |
| cfg_fid_inv | input | 1 | Field polarity: 0 = raw field 0 is odd, 1 = raw field 1 is odd |
| in_valid | input | 1 | Qualifies `in_data` and the external sync pins |
| in_data | input | 8 | Video sample |
| ext_hblank | input | 1 | External horizontal blanking, high outside the active picture |
| ext_vblank | input | 1 | External vertical blanking |
| ext_fid | input | 1 | External raw field identity |
| act_valid | output | 1 | Active picture sample present on `act_data` |
| act_data | output | 8 | Delayed picture sample |
| line_cnt | output | clog2(LINES_625) | Line number within the frame |
| field_odd | output | 1 | Current field is odd |
| sol_pulse | output | 1 | Start of active line |
| sof_pulse | output | 1 | Field change |
| sync_err | output | 1 | Embedded line timing lost |

## Verification
A stale vertical-blank or field register shows up as picture samples that appear or vanish for whole lines. It also shows as a `field_odd` flag that lags by a line, and each of these shows at the very next end-of-active event. An off-by-one in the window counter shifts the first or last marked sample by one clock, on every line. A wrong line counter or wrap limit gives a `line_cnt` that drifts away from the line index within a frame. A lost code detector or history register holds `sync_err` high about LINE_CLKS+MARGIN clocks later. The sweep covers both modes, both polarities, both standards and streams with gaps.

// File: rtl/vsync_pkg.sv
package vsync_pkg;
  typedef struct packed {
    logic sav;   // start of active picture
    logic eav;   // end of active picture
    logic fld;   // raw field bit
    logic vbl;   // vertical blanking
  } tim_ev_t;

  localparam logic [7:0] CODE_LEAD = 8'hFF;
  localparam logic [7:0] CODE_ZERO = 8'h00;
  localparam int         BIT_FLD   = 6;
  localparam int         BIT_VBL   = 5;
  localparam int         BIT_HOR   = 4;
  localparam int         PREAMBLE  = 3;
endpackage

// File: rtl/trs_decoder.sv
module trs_decoder
  import vsync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output tim_ev_t    ev
);
  logic [7:0] hist [PREAMBLE];   // hist[0] newest
  logic       pre_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PREAMBLE; i++) hist[i] <= '0;
    end else if (in_valid) begin
      hist[0] <= in_data;
      for (int i = 1; i < PREAMBLE; i++) hist[i] <= hist[i-1];
    end
  end

  always_comb begin
    pre_ok = (hist[PREAMBLE-1] == CODE_LEAD);
    for (int i = 0; i < PREAMBLE - 1; i++)
      pre_ok = pre_ok && (hist[i] == CODE_ZERO);
    ev.sav = in_valid && pre_ok && !in_data[BIT_HOR];
    ev.eav = in_valid && pre_ok &&  in_data[BIT_HOR];
    ev.fld = in_data[BIT_FLD];
    ev.vbl = in_data[BIT_VBL];
  end
endmodule

// File: rtl/ext_sync_decoder.sv
module ext_sync_decoder
  import vsync_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  logic    hblank,
  input  logic    vblank,
  input  logic    fid,
  output tim_ev_t ev
);
  logic hb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hb_q <= 1'b0;
    else if (in_valid) hb_q <= hblank;
  end

  always_comb begin
    ev.sav = in_valid &&  hb_q && !hblank;
    ev.eav = in_valid && !hb_q &&  hblank;
    ev.fld = fid;
    ev.vbl = vblank;
  end
endmodule

// File: rtl/sync_timing_core.sv
module sync_timing_core
  import vsync_pkg::*;
#(
  parameter int ACT_SAMPLES = 1440,
  parameter int LINES_525   = 525,
  parameter int LINES_625   = 625,
  parameter int LINE_CLKS   = 1716,
  parameter int MARGIN      = 64,
  localparam int AW    = $clog2(ACT_SAMPLES + 1),
  localparam int LW    = $clog2(LINES_625),
  localparam int LIMIT = LINE_CLKS + MARGIN,
  localparam int EW    = $clog2(LIMIT + 1)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_ext_mode,
  input  logic          cfg_std625,
  input  logic          cfg_fid_inv,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  tim_ev_t       ev,
  output logic          act_valid,
  output logic [7:0]    act_data,
  output logic [LW-1:0] line_cnt,
  output logic          field_odd,
  output logic          sol_pulse,
  output logic          sof_pulse,
  output logic          sync_err
);
  logic [AW-1:0] remain;
  logic          vbl_q;
  logic [LW-1:0] last_line;
  logic          odd_new;
  logic [EW-1:0] gap_cnt;

  assign last_line = cfg_std625 ? LW'(LINES_625 - 1) : LW'(LINES_525 - 1);
  assign odd_new   = (ev.fld == cfg_fid_inv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_valid <= 1'b0;
      act_data  <= '0;
      line_cnt  <= '0;
      field_odd <= 1'b0;
      sol_pulse <= 1'b0;
      sof_pulse <= 1'b0;
      remain    <= '0;
      vbl_q     <= 1'b0;
    end else begin
      act_valid <= 1'b0;
      sol_pulse <= 1'b0;
      sof_pulse <= 1'b0;
      if (in_valid) begin
        act_data <= in_data;
        if (ev.sav) begin
          sol_pulse <= 1'b1;
          if (cfg_ext_mode) begin
            act_valid <= !vbl_q;
            remain    <= AW'(ACT_SAMPLES - 1);
          end else begin
            remain    <= AW'(ACT_SAMPLES);
          end
        end else if (remain != '0) begin
          act_valid <= !vbl_q;
          remain    <= remain - 1'b1;
        end
        if (ev.eav) begin
          remain <= '0;
          vbl_q  <= ev.vbl;
          if (odd_new != field_odd) begin
            sof_pulse <= 1'b1;
            field_odd <= odd_new;
          end
          if (odd_new && !field_odd)   line_cnt <= '0;
          else if (line_cnt >= last_line) line_cnt <= '0;
          else                          line_cnt <= line_cnt + 1'b1;
        end
      end
    end
  end

  // line-loss watch, embedded mode only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt  <= '0;
      sync_err <= 1'b0;
    end else begin
      if (cfg_ext_mode || ev.eav)   gap_cnt <= '0;
      else if (gap_cnt < EW'(LIMIT)) gap_cnt <= gap_cnt + 1'b1;
      sync_err <= !cfg_ext_mode && !ev.eav && (gap_cnt >= EW'(LIMIT));
    end
  end
endmodule

// File: rtl/video_sync_proc.sv
module video_sync_proc
  import vsync_pkg::*;
#(
  parameter int ACT_SAMPLES = 1440,
  parameter int LINES_525   = 525,
  parameter int LINES_625   = 625,
  parameter int LINE_CLKS   = 1716,
  parameter int MARGIN      = 64,
  localparam int LW = $clog2(LINES_625)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_ext_mode,
  input  logic          cfg_std625,
  input  logic          cfg_fid_inv,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          ext_hblank,
  input  logic          ext_vblank,
  input  logic          ext_fid,
  output logic          act_valid,
  output logic [7:0]    act_data,
  output logic [LW-1:0] line_cnt,
  output logic          field_odd,
  output logic          sol_pulse,
  output logic          sof_pulse,
  output logic          sync_err
);
  tim_ev_t emb_ev, ext_ev, sel_ev;

  trs_decoder u_trs (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .ev(emb_ev)
  );

  ext_sync_decoder u_ext (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .hblank(ext_hblank), .vblank(ext_vblank), .fid(ext_fid), .ev(ext_ev)
  );

  assign sel_ev = cfg_ext_mode ? ext_ev : emb_ev;

  sync_timing_core #(
    .ACT_SAMPLES(ACT_SAMPLES), .LINES_525(LINES_525), .LINES_625(LINES_625),
    .LINE_CLKS(LINE_CLKS), .MARGIN(MARGIN)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .cfg_ext_mode(cfg_ext_mode), .cfg_std625(cfg_std625),
    .cfg_fid_inv(cfg_fid_inv), .in_valid(in_valid), .in_data(in_data), .ev(sel_ev),
    .act_valid(act_valid), .act_data(act_data), .line_cnt(line_cnt),
    .field_odd(field_odd), .sol_pulse(sol_pulse), .sof_pulse(sof_pulse),
    .sync_err(sync_err)
  );
endmodule

// File: rtl/vsync_checker.sv
module vsync_checker #(
  parameter int LINES_625 = 625,
  parameter int LW        = 10
)(
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          cfg_ext_mode,
  input logic          act_valid,
  input logic          sol_pulse,
  input logic          sof_pulse,
  input logic          field_odd,
  input logic          sync_err,
  input logic [LW-1:0] line_cnt
);
  assert_act_needs_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |-> $past(in_valid));

  assert_sol_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sol_pulse |=> !sol_pulse);

  assert_sof_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |=> !sof_pulse);

  assert_field_moves_with_sof_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sof_pulse |-> $stable(field_odd));

  assert_odd_start_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_pulse && field_odd) |-> (line_cnt == '0));

  assert_line_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(line_cnt) < LINES_625);

  assert_ext_no_error_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_ext_mode) |-> !sync_err);

  assert_sol_sof_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sol_pulse && sof_pulse));
endmodule

bind video_sync_proc vsync_checker #(.LINES_625(LINES_625), .LW(LW)) u_vsync_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_ext_mode(cfg_ext_mode),
  .act_valid(act_valid), .sol_pulse(sol_pulse), .sof_pulse(sof_pulse),
  .field_odd(field_odd), .sync_err(sync_err), .line_cnt(line_cnt)
);

// File: tb/tb_video_sync_proc.sv
module tb_video_sync_proc;
  localparam int CLK_PERIOD = 10;
  localparam int ACT  = 8;
  localparam int NA   = 11;
  localparam int NB   = 15;
  localparam int LCLK = 24;
  localparam int MRG  = 8;
  localparam int LW   = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_ext_mode = 1'b0, cfg_std625 = 1'b0, cfg_fid_inv = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic ext_hblank = 1'b0, ext_vblank = 1'b0, ext_fid = 1'b0;
  logic act_valid, field_odd, sol_pulse, sof_pulse, sync_err;
  logic [7:0] act_data;
  logic [LW-1:0] line_cnt;

  int checks = 0, errors = 0, cycles = 0;
  int gap_on = 0, gcnt = 0;
  int prev_odd = 0, seen_start = 0, start_l = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  video_sync_proc #(.ACT_SAMPLES(ACT), .LINES_525(NA), .LINES_625(NB),
                    .LINE_CLKS(LCLK), .MARGIN(MRG)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_ext_mode(cfg_ext_mode), .cfg_std625(cfg_std625),
    .cfg_fid_inv(cfg_fid_inv), .in_valid(in_valid), .in_data(in_data),
    .ext_hblank(ext_hblank), .ext_vblank(ext_vblank), .ext_fid(ext_fid),
    .act_valid(act_valid), .act_data(act_data), .line_cnt(line_cnt),
    .field_odd(field_odd), .sol_pulse(sol_pulse), .sof_pulse(sof_pulse),
    .sync_err(sync_err));

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      report();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [7:0] d, input logic hb, input logic vb, input logic fd);
    if (gap_on != 0) begin
      gcnt++;
      if (gcnt % 4 == 0) begin
        in_valid = 1'b0;
        in_data  = 8'h00;
        @(negedge clk);
        chk(act_valid == 1'b0 && sol_pulse == 1'b0, "R9 idle cycle output", act_valid, 0);
      end
    end
    in_valid = 1'b1; in_data = d; ext_hblank = hb; ext_vblank = vb; ext_fid = fd;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; ext_hblank = 1'b0;
    repeat (3) @(negedge clk);
    chk(act_valid == 0 && sol_pulse == 0 && sof_pulse == 0 && field_odd == 0 &&
        sync_err == 0 && line_cnt == 0, "R1 reset state", line_cnt, 0);
    rst_n = 1'b1;
    prev_odd = 0; seen_start = 0; gcnt = 0;
  endtask

  task automatic eav_checks(input int l, input int n, input int odd);
    int exp_sof, exp_l;
    exp_sof = (odd != prev_odd);
    chk(sof_pulse == exp_sof, "R5 sof pulse", sof_pulse, exp_sof);
    chk(field_odd == odd, "R5 field flag", field_odd, odd);
    chk(sol_pulse == 0, "R4 no sol at end code", sol_pulse, 0);
    if (exp_sof && odd) begin seen_start = 1; start_l = l; end
    if (seen_start != 0) begin
      exp_l = (l - start_l + n) % n;
      chk(int'(line_cnt) == exp_l, "R6 line count", line_cnt, exp_l);
    end
    chk(sync_err == 0, "R8 R10 no error on regular lines", sync_err, 0);
    prev_odd = odd;
  endtask

  task automatic send_line(input int l, input int n);
    int half, f, v, odd;
    logic [7:0] xy, d;
    half = (n + 1) / 2;
    f = (l >= half);
    v = (l < 2) || (l >= half && l < half + 2);
    odd = (f == int'(cfg_fid_inv));
    if (cfg_ext_mode == 1'b0) begin
      xy = {1'b1, f[0], v[0], 1'b1, 4'(l) ^ 4'hA};   // R2 protection bits garbage
      step(8'hFF, 1'b0, 1'b0, 1'b0);
      chk(act_valid == 0, "R3 window closed after last sample", act_valid, 0);
      step(8'h00, 1'b0, 1'b0, 1'b0);
      step(8'h00, 1'b0, 1'b0, 1'b0);
      step(xy, 1'b0, 1'b0, 1'b0);
      eav_checks(l, n, odd);
      for (int i = 0; i < 8; i++) step(8'h10, 1'b0, 1'b0, 1'b0);
      xy = {1'b1, f[0], v[0], 1'b0, 4'(l) ^ 4'h5};
      step(8'hFF, 1'b0, 1'b0, 1'b0);
      step(8'h00, 1'b0, 1'b0, 1'b0);
      step(8'h00, 1'b0, 1'b0, 1'b0);
      step(xy, 1'b0, 1'b0, 1'b0);
      chk(sol_pulse == 1, "R2 R4 start code gives sol", sol_pulse, 1);
      chk(act_valid == 0, "R3 code byte not active", act_valid, 0);
      for (int i = 0; i < ACT; i++) begin
        d = 8'h20 + 8'(8 * (l % 16) + i);
        step(d, 1'b0, 1'b0, 1'b0);
        chk(act_valid == (v == 0), "R3 active flag", act_valid, (v == 0));
        if (v == 0) chk(act_data == d, "R3 active data", act_data, d);
        chk(sol_pulse == 0, "R4 sol single", sol_pulse, 0);
      end
    end else begin
      step(8'h10, 1'b1, v[0], f[0]);
      chk(act_valid == 0, "R3 R7 window closed at blank", act_valid, 0);
      eav_checks(l, n, odd);
      for (int i = 0; i < LCLK - ACT - 1; i++) step(8'h10, 1'b1, 1'b0, 1'b0);
      for (int i = 0; i < ACT; i++) begin
        d = 8'h20 + 8'(8 * (l % 16) + i);
        step(d, 1'b0, 1'b0, 1'b0);
        chk(sol_pulse == (i == 0), "R4 R7 sol at falling blank", sol_pulse, (i == 0));
        chk(act_valid == (v == 0), "R3 R7 active flag", act_valid, (v == 0));
        if (v == 0) chk(act_data == d, "R3 active data", act_data, d);
      end
    end
  endtask

  initial begin
    @(negedge clk);
    for (int m = 0; m < 2; m++)
      for (int inv = 0; inv < 2; inv++)
        for (int s = 0; s < 2; s++)
          for (int g = 0; g < 2; g++) begin
            int n;
            cfg_ext_mode = m[0]; cfg_fid_inv = inv[0]; cfg_std625 = s[0];
            gap_on = g;
            n = (s != 0) ? NB : NA;
            do_reset();
            for (int fr = 0; fr < 3; fr++)
              for (int l = 0; l < n; l++) send_line(l, n);
            if (g == 0) begin
              // stream without any end code
              for (int i = 0; i < LCLK + MRG + 8; i++) step(8'h10, 1'b0, 1'b0, 1'b0);
              if (m == 0) begin
                chk(sync_err == 1, "R8 error after lost line", sync_err, 1);
                step(8'hFF, 1'b0, 1'b0, 1'b0); step(8'h00, 1'b0, 1'b0, 1'b0);
                step(8'h01, 1'b0, 1'b0, 1'b0); step(8'h90, 1'b0, 1'b0, 1'b0);
                chk(sync_err == 1, "R8 near-miss code keeps error", sync_err, 1);
                seen_start = 0;
                send_line(0, n);
                chk(sync_err == 0, "R8 error cleared by end code", sync_err, 0);
              end else begin
                chk(sync_err == 0, "R10 no error in external mode", sync_err, 0);
              end
            end
          end
    report();
  end
endmodule